// File: doc/BRIEF.md
# Telecom Frame Pulse and Backplane Clock Generator

This block runs from a 16.384 MHz master clock. It produces the 8 kHz frame strobes and the binary-divided square clocks used by serial time-division backplanes. A free-running counter of master cycles marks each 125 µs frame as 2048 cycles. Three registered frame pulses are decoded from that counter. Each pulse has its own width and polarity, and all three sit around the frame boundary. The 8.192, 4.096 and 2.048 MHz clocks come from the low counter bits. Every one of them therefore rises on the boundary cycle, and all outputs keep a fixed phase relationship to one another.

A small alignment state machine has three states. ST_HOLD is the state while the synchronous reset is asserted. ST_ALIGN means a counter reload has happened and the first boundary after it is still pending. ST_RUN is free-running operation. The machine has four transitions:
- *reset*: from any state to ST_HOLD.
- *release*: ST_HOLD to ST_ALIGN on the first edge without reset.
- *land*: ST_ALIGN (or ST_HOLD) to ST_RUN on the edge where the counter wraps to zero.
- *realign*: ST_RUN to ST_ALIGN when a resync strobe is sampled.

A realign reloads the counter to eight cycles before the boundary, so the next boundary falls on a known cycle. The reset does the same. A strobe seen outside ST_RUN is ignored.

Top module: `tfp_frame_gen`

## Requirements
- R1: While reset is sampled high at a clock edge, the outputs after that edge are inactive: frm_wide_n_o=1, frm_mid_o=0, frm_narrow_n_o=1, and all three divided clocks are 0. A resync strobe sampled together with reset has no further effect.
- R2: In free-running operation the frame pulses repeat every 2048 master cycles, which is 125 µs at 16.384 MHz.
- R3: The narrow pulse frm_narrow_n_o is active low for exactly one master cycle, the boundary cycle (count 0).
- R4: The middle pulse frm_mid_o is active high for exactly two cycles: the last cycle of a frame (count 2047) and the boundary cycle (count 0).
- R5: The wide pulse frm_wide_n_o is active low for exactly four cycles, counts 2046, 2047, 0 and 1. It therefore always covers the middle pulse.
- R6: clk_8m_o, clk_4m_o and clk_2m_o equal the inverted count bits 0, 1 and 2. Each has a 50% duty cycle, and all three are high on the boundary cycle, so each rises at the frame boundary.
- R7: After reset, if the last edge with reset high is edge E, then the narrow pulse is asserted after edge E+8.
- R8: A resync strobe sampled in ST_RUN at edge E reloads the counter to 2040. The narrow pulse is then asserted after edge E+8, and the frame continues from there, whatever count the strobe arrived at.
- R9: A resync strobe sampled in ST_HOLD or ST_ALIGN, up to and including the edge where the pending boundary lands, is ignored. It does not move the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| resync_i | input | 1 | Frame resync strobe, sampled on rising edges |
| clk_8m_o | output | 1 | Master clock divided by 2 |
| clk_4m_o | output | 1 | Master clock divided by 4 |
| clk_2m_o | output | 1 | Master clock divided by 8 |
| frm_wide_n_o | output | 1 | Four-cycle active-low frame pulse |
| frm_mid_o | output | 1 | Two-cycle active-high frame pulse |
| frm_narrow_n_o | output | 1 | One-cycle active-low frame pulse |

## Verification
The bench sweeps resync strobes across twenty-four consecutive counts around the frame wrap. That range includes counts inside each pulse window and the reload count itself. A design that reloaded one cycle late or early, or that decoded its windows from the current count instead of the next count, would move the boundary off the eighth edge or clip a pulse. A second strobe is placed during alignment and a third on the landing edge. A design that restarted alignment on every strobe would push the boundary later, and one that ignored strobes for too long would miss the following realign. Reset is asserted together with a strobe, and reset is re-applied in mid-run. A design whose clocks did not come from the same counter bits would show a clock edge that is not on the boundary.

// File: rtl/tfp_pkg.sv
`timescale 1ns/1ps
package tfp_pkg;

    // Alignment controller states.
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RUN   = 2'd2
    } sync_state_e;

    // True when a count lies in a window of 'width' cycles placed around the
    // frame wrap: width/2 cycles before count 0, the rest from count 0 on.
    function automatic logic in_window(input int unsigned pos,
                                       input int unsigned width,
                                       input int unsigned frame_len);
        int unsigned shifted;
        shifted = (pos + (width / 2)) % frame_len;
        return (shifted < width);
    endfunction

endpackage

// File: rtl/tfp_sync_fsm.sv
`timescale 1ns/1ps
module tfp_sync_fsm #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             resync_i,
    input  logic [CNT_W-1:0] cnt_q,
    output logic             reload_o
);
    import tfp_pkg::*;

    localparam logic [CNT_W-1:0] LAST_CNT = {CNT_W{1'b1}};

    sync_state_e state_q;
    sync_state_e state_d;
    logic        wrap_now;

    // The counter wraps to zero on this edge.
    assign wrap_now = (cnt_q == LAST_CNT);

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (wrap_now) begin
                    state_d = ST_RUN;      // land (only when the lead is one cycle)
                end else begin
                    state_d = ST_ALIGN;    // release
                end
            end
            ST_ALIGN: begin
                if (wrap_now) begin
                    state_d = ST_RUN;      // land
                end
            end
            ST_RUN: begin
                if (resync_i) begin
                    state_d = ST_ALIGN;    // realign
                end
            end
        endcase
    end

    // Output logic: only a strobe seen in ST_RUN reloads the counter.
    always_comb begin
        reload_o = 1'b0;
        unique case (state_q)
            ST_HOLD:  reload_o = 1'b0;
            ST_ALIGN: reload_o = 1'b0;
            ST_RUN:   reload_o = resync_i;
        endcase
    end

endmodule

// File: rtl/tfp_frame_ctr.sv
`timescale 1ns/1ps
module tfp_frame_ctr #(
    parameter int unsigned CNT_W    = 11,
    parameter int unsigned LOAD_VAL = 2040
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD_VAL);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    // Value the counter takes on the coming edge when reset is low.
    always_comb begin
        if (reload_i) begin
            cnt_nxt = LOAD_V;
        end else begin
            cnt_nxt = cnt_q + ONE_V;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= LOAD_V;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/tfp_pulse_bank.sv
`timescale 1ns/1ps
module tfp_pulse_bank #(
    parameter int unsigned           CNT_W     = 11,
    parameter int unsigned           NUM_PULSE = 3,
    parameter logic [NUM_PULSE*16-1:0] WIDTHS  = {16'd4, 16'd2, 16'd1},
    parameter logic [NUM_PULSE-1:0]  ACT_LOW   = 3'b101
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_W-1:0]     cnt_nxt,
    output logic [NUM_PULSE-1:0] pulse_q
);
    import tfp_pkg::*;

    localparam int unsigned FRAME_LEN = 32'd1 << CNT_W;

    for (genvar gi = 0; gi < NUM_PULSE; gi++) begin : g_pulse
        localparam int unsigned WIN = 32'(WIDTHS[gi*16 +: 16]);
        localparam logic        POL = ACT_LOW[gi];

        logic hit;
        assign hit = in_window(32'(cnt_nxt), WIN, FRAME_LEN);

        // Registered from the next count, so the pulse lines up with the counter.
        always_ff @(posedge clk) begin
            if (rst) begin
                pulse_q[gi] <= POL;
            end else begin
                pulse_q[gi] <= POL ^ hit;
            end
        end
    end

endmodule

// File: rtl/tfp_clk_div.sv
`timescale 1ns/1ps
module tfp_clk_div #(
    parameter int unsigned NUM_DIV = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DIV-1:0] cnt_low_nxt,
    output logic [NUM_DIV-1:0] div_q
);
    // Divider k is high in the lower half of each 2^(k+1) block, so every
    // divided clock rises when the count wraps to zero.
    for (genvar gk = 0; gk < NUM_DIV; gk++) begin : g_div
        always_ff @(posedge clk) begin
            if (rst) begin
                div_q[gk] <= 1'b0;
            end else begin
                div_q[gk] <= ~cnt_low_nxt[gk];
            end
        end
    end

endmodule

// File: rtl/tfp_frame_gen.sv
`timescale 1ns/1ps
module tfp_frame_gen #(
    parameter int unsigned CNT_W      = 11,
    parameter int unsigned LEAD       = 8,
    parameter int unsigned WIDE_CYC   = 4,
    parameter int unsigned MID_CYC    = 2,
    parameter int unsigned NARROW_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic resync_i,
    output logic clk_8m_o,
    output logic clk_4m_o,
    output logic clk_2m_o,
    output logic frm_wide_n_o,
    output logic frm_mid_o,
    output logic frm_narrow_n_o
);
    localparam int unsigned FRAME_LEN = 32'd1 << CNT_W;
    localparam int unsigned LOAD_VAL  = FRAME_LEN - LEAD;
    localparam int unsigned NUM_DIV   = 3;
    localparam int unsigned NUM_PULSE = 3;
    // Pulse slots: 0 narrow, 1 mid, 2 wide.
    localparam logic [NUM_PULSE*16-1:0] WIDTHS =
        {16'(WIDE_CYC), 16'(MID_CYC), 16'(NARROW_CYC)};
    localparam logic [NUM_PULSE-1:0] ACT_LOW = 3'b101;

    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     cnt_nxt;
    logic                 reload;
    logic [NUM_PULSE-1:0] pulses;
    logic [NUM_DIV-1:0]   divs;

    tfp_sync_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .resync_i (resync_i),
        .cnt_q    (cnt_q),
        .reload_o (reload)
    );

    tfp_frame_ctr #(
        .CNT_W    (CNT_W),
        .LOAD_VAL (LOAD_VAL)
    ) ctr_i (
        .clk      (clk),
        .rst      (rst),
        .reload_i (reload),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt)
    );

    tfp_pulse_bank #(
        .CNT_W     (CNT_W),
        .NUM_PULSE (NUM_PULSE),
        .WIDTHS    (WIDTHS),
        .ACT_LOW   (ACT_LOW)
    ) pulse_i (
        .clk     (clk),
        .rst     (rst),
        .cnt_nxt (cnt_nxt),
        .pulse_q (pulses)
    );

    tfp_clk_div #(
        .NUM_DIV (NUM_DIV)
    ) div_i (
        .clk         (clk),
        .rst         (rst),
        .cnt_low_nxt (cnt_nxt[NUM_DIV-1:0]),
        .div_q       (divs)
    );

    assign clk_8m_o       = divs[0];
    assign clk_4m_o       = divs[1];
    assign clk_2m_o       = divs[2];
    assign frm_narrow_n_o = pulses[0];
    assign frm_mid_o      = pulses[1];
    assign frm_wide_n_o   = pulses[2];

endmodule

// File: rtl/tfp_frame_gen_chk.sv
`timescale 1ns/1ps
module tfp_frame_gen_chk (
    input logic clk,
    input logic rst,
    input logic resync_i,
    input logic clk_8m_o,
    input logic clk_4m_o,
    input logic clk_2m_o,
    input logic frm_wide_n_o,
    input logic frm_mid_o,
    input logic frm_narrow_n_o
);
    logic seen_rst = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rst <= 1'b1;
        end
    end

    // R1: an edge with reset leaves every output inactive.
    p_idle_in_reset_r1: assert property (@(posedge clk) disable iff (!seen_rst)
        rst |=> (frm_wide_n_o && !frm_mid_o && frm_narrow_n_o &&
                 !clk_8m_o && !clk_4m_o && !clk_2m_o));

    // R3: the narrow pulse lasts a single cycle.
    p_narrow_single_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(frm_narrow_n_o) |=> frm_narrow_n_o);

    // R4: the middle pulse is at least two cycles unless a reload cuts it.
    p_mid_two_r4: assert property (@(posedge clk) disable iff (rst || resync_i)
        $rose(frm_mid_o) |=> frm_mid_o);

    // R5: the wide pulse always covers the middle pulse.
    p_wide_covers_mid_r5: assert property (@(posedge clk) disable iff (rst)
        frm_mid_o |-> !frm_wide_n_o);

    // R4: the boundary cycle carries the middle pulse too.
    p_narrow_in_mid_r4: assert property (@(posedge clk) disable iff (rst)
        !frm_narrow_n_o |-> frm_mid_o);

    // R6: all divided clocks are high on the boundary cycle.
    p_clks_high_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        !frm_narrow_n_o |-> (clk_8m_o && clk_4m_o && clk_2m_o));

endmodule

bind tfp_frame_gen tfp_frame_gen_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .resync_i       (resync_i),
    .clk_8m_o       (clk_8m_o),
    .clk_4m_o       (clk_4m_o),
    .clk_2m_o       (clk_2m_o),
    .frm_wide_n_o   (frm_wide_n_o),
    .frm_mid_o      (frm_mid_o),
    .frm_narrow_n_o (frm_narrow_n_o)
);

// File: tb/tfp_frame_gen_tb_top.sv
`timescale 1ns/1ps
module tfp_frame_gen_tb_top;

    localparam int FRAME = 2048;
    localparam int LOADV = 2040;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic resync = 1'b0;
    logic clk_8m, clk_4m, clk_2m, wide_n, mid, narrow_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model: count, state (0 hold, 1 align, 2 run), reset flag at last edge
    int mb = LOADV;
    int mst = 0;
    bit mr = 1'b1;

    always #2.5 clk = ~clk;

    tfp_frame_gen dut_i (
        .clk            (clk),
        .rst            (rst),
        .resync_i       (resync),
        .clk_8m_o       (clk_8m),
        .clk_4m_o       (clk_4m),
        .clk_2m_o       (clk_2m),
        .frm_wide_n_o   (wide_n),
        .frm_mid_o      (mid),
        .frm_narrow_n_o (narrow_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int e_narrow, e_mid, e_wide, e8, e4, e2;
        if (mr) begin
            chk(narrow_n == 1'b1, "R1", "narrow in reset", narrow_n, 1);
            chk(mid == 1'b0,      "R1", "mid in reset", mid, 0);
            chk(wide_n == 1'b1,   "R1", "wide in reset", wide_n, 1);
            chk({clk_8m, clk_4m, clk_2m} == 3'b000, "R1", "clocks in reset",
                {clk_8m, clk_4m, clk_2m}, 0);
        end else begin
            e_narrow = (mb == 0) ? 0 : 1;
            e_mid    = (mb == FRAME - 1 || mb == 0) ? 1 : 0;
            e_wide   = (mb >= FRAME - 2 || mb <= 1) ? 0 : 1;
            e8 = ((mb >> 0) & 1) ^ 1;
            e4 = ((mb >> 1) & 1) ^ 1;
            e2 = ((mb >> 2) & 1) ^ 1;
            chk(int'(narrow_n) == e_narrow, "R3", "narrow pulse", narrow_n, e_narrow);
            chk(int'(mid) == e_mid,         "R4", "mid pulse", mid, e_mid);
            chk(int'(wide_n) == e_wide,     "R5", "wide pulse", wide_n, e_wide);
            chk(int'(clk_8m) == e8,         "R6", "clk div2", clk_8m, e8);
            chk(int'(clk_4m) == e4,         "R6", "clk div4", clk_4m, e4);
            chk(int'(clk_2m) == e2,         "R6", "clk div8", clk_2m, e2);
        end
    endtask

    // One master cycle: drive now (negedge), model the edge, compare at negedge.
    task automatic step(input logic r, input logic s);
        bit was_last;
        rst = r;
        resync = s;
        @(posedge clk);
        mr = r;
        if (r) begin
            mb = LOADV;
            mst = 0;
        end else if (mst == 2 && s) begin
            mb = LOADV;
            mst = 1;
        end else begin
            was_last = (mb == FRAME - 1);
            mb = (mb + 1) % FRAME;
            if (mst != 2) mst = was_last ? 2 : 1;
        end
        @(negedge clk);
        compare();
    endtask

    // Steps until the narrow pulse shows; returns how many steps it took.
    task automatic to_boundary(output int n);
        n = 0;
        do begin
            step(1'b0, 1'b0);
            n++;
        end while (narrow_n && n < 5000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        // R1: reset held for several cycles, once with a strobe alongside
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);

        // R7: first boundary eight edges after the last reset edge
        to_boundary(n);
        chk(n == 8, "R7", "edges from reset to boundary", n, 8);

        // R2: frame period
        for (int i = 0; i < 2; i++) begin
            to_boundary(n);
            chk(n == FRAME, "R2", "frame period", n, FRAME);
        end

        // R8: strobe in mid-frame
        while (mb != 100) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        to_boundary(n);
        chk(n == 8, "R8", "boundary after resync", n, 8);

        // R9: second strobe during alignment is ignored
        step(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        to_boundary(n);
        chk(n == 4, "R9", "strobe during align ignored", n, 4);

        // R9: strobe on the landing edge is ignored
        step(1'b0, 1'b1);
        for (int i = 0; i < 7; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        chk(narrow_n == 1'b0, "R9", "landing edge boundary", narrow_n, 0);
        to_boundary(n);
        chk(n == FRAME, "R9", "frame after ignored landing strobe", n, FRAME);

        // R8: sweep strobe position over counts around the wrap
        for (int i = 0; i < 24; i++) begin
            int target;
            target = (2036 + i) % FRAME;
            while (mb != target) step(1'b0, 1'b0);
            step(1'b0, 1'b1);
            to_boundary(n);
            chk(n == 8, "R8", "sweep boundary after resync", n, 8);
        end

        // R1/R7: reset in mid-run together with a strobe
        while (mb != 500) step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        to_boundary(n);
        chk(n == 8, "R7", "boundary after mid-run reset", n, 8);
        to_boundary(n);
        chk(n == FRAME, "R2", "period after mid-run reset", n, FRAME);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule